// File: doc/BRIEF.md
# CRC-Guarded Register File

This block is a processor register file that detects soft errors, single-bit and multi-bit, in the words it holds. Every write computes a short checksum over the whole register word. The checksum goes into a side store, separate from the data array. Each side-store entry is kept as a single-error-correcting, double-error-detecting (SECDED) Hamming codeword. Every read recomputes the checksum of the word that is in the register at that moment and compares it with the stored value. A difference raises that read port's error flag.

There is one synchronous write port and two independent read ports. Read data and flags are registered. A fault-injection port XORs masks into a chosen register's data word and into its checksum codeword. The checksum is not recomputed when this happens. This lets a test create upsets of any shape and watch the flags respond. The data word width is a parameter: 32 by default, 64 also supported.

Top module: `crc_regfile`

## Requirements
- R1: After reset, all 32 registers read as zero on both ports, and no flag is raised.
- R2: A word written to address `wrAddr` is returned by a later read of that address. Read data and flags appear on the clock edge after the read address is presented.
- R3: The checksum is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00 and no final XOR, taken over the word from the MSB first. A data corruption whose mask is a multiple of that polynomial leaves the flag low. A register with no corruption never raises the flag.
- R4: Any injected data upset of odd weight, or any burst of 8 bits or fewer, raises `rdErr` on every read of that register until it is rewritten. The corrupted word is returned. Other registers are unaffected.
- R5: Writing a register clears any earlier data or checksum corruption of that register.
- R6: A read and a write to the same address in the same cycle return the old word and the old check result. The new word is seen from the next read.
- R7: The two read ports operate independently. Each port reports its own data, `rdErr` and `storeErr` for its own address.
- R8: A single flipped bit anywhere in a register's 13-bit stored codeword is corrected silently. The read reports no flag, unless the data itself is corrupted.
- R9: Two flipped bits in a stored codeword raise `storeErr`, and also raise `rdErr`, on reads of that register.
- R10: When a write and an injection target the same register in the same cycle, the write wins and the injection is dropped. An injection into a different register in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Write address |
| wrData | input | DATA_W | Write data |
| injEn | input | 1 | Fault-injection strobe |
| injAddr | input | 5 | Register to corrupt |
| injDataMask | input | DATA_W | Bits XORed into the data word |
| injCodeMask | input | 13 | Bits XORed into the stored checksum codeword |
| rdAddrA | input | 5 | Port A read address |
| rdDataA | output | DATA_W | Port A read data, registered |
| rdErrA | output | 1 | Port A checksum mismatch |
| storeErrA | output | 1 | Port A uncorrectable codeword |
| rdAddrB | input | 5 | Port B read address |
| rdDataB | output | DATA_W | Port B read data, registered |
| rdErrB | output | 1 | Port B checksum mismatch |
| storeErrB | output | 1 | Port B uncorrectable codeword |

## Verification
A stale or wrong stored checksum shows up as `rdErr` on the first read of the affected register, one edge after its address is presented. It stays visible on every later read until that register is written again. A wrong injection or write decode shows up as a changed word, or a flag, on some other register that the bench reads back. A bad side-store decoder shows up as a missing or extra `storeErr` on codeword flips of weight one and two.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int REG_COUNT  = 32;
  localparam int ADDR_W     = $clog2(REG_COUNT);
  localparam int CRC_W      = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam int PAR_W      = 4;
  localparam int CODE_W     = CRC_W + PAR_W + 1;
  localparam int READ_PORTS = 2;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrSel;
    logic [REG_COUNT-1:0] injSel;
  } crfStrobes_t;

  typedef struct packed {
    logic [CRC_W-1:0] data;
    logic             dbl;
  } hamResult_t;

  // Positions 1..CODE_W-1 form a Hamming code (parity at powers of two),
  // position 0 holds overall parity.
  function automatic logic [CODE_W-1:0] hamEncode(input logic [CRC_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[k];
        k++;
      end
    end
    for (int p = 0; p < PAR_W; p++) begin
      for (int pos = 1; pos < CODE_W; pos++) begin
        if ((((pos >> p) & 1) == 1) && ((pos & (pos - 1)) != 0))
          cw[1 << p] = cw[1 << p] ^ cw[pos];
      end
    end
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  function automatic hamResult_t hamDecode(input logic [CODE_W-1:0] cw);
    logic [PAR_W-1:0]  syn;
    logic [CODE_W-1:0] fixed;
    hamResult_t        res;
    int k;
    syn   = '0;
    fixed = cw;
    res   = '0;
    for (int pos = 1; pos < CODE_W; pos++)
      if (cw[pos]) syn = syn ^ PAR_W'(pos);
    if (syn != '0) begin
      if (^cw) begin
        if (int'(syn) < CODE_W) fixed[syn] = ~fixed[syn];
        else                    res.dbl = 1'b1;
      end else begin
        res.dbl = 1'b1;
      end
    end
    k = 0;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        res.data[k] = fixed[pos];
        k++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/crf_ctrl.sv
module crf_ctrl
  import crf_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  output crfStrobes_t       strb
);
  logic injClash;

  assign injClash = wrEn && (wrAddr == injAddr);

  always_comb begin
    strb = '0;
    if (wrEn) strb.wrSel[wrAddr] = 1'b1;
    if (injEn && !injClash) strb.injSel[injAddr] = 1'b1;
  end
endmodule

// File: rtl/crf_datapath.sv
module crf_datapath
  import crf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  crfStrobes_t                           strb,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic [DATA_W-1:0]                     injDataMask,
  input  logic [CODE_W-1:0]                     injCodeMask,
  input  logic [READ_PORTS-1:0][ADDR_W-1:0]     rdAddr,
  output logic [READ_PORTS-1:0][DATA_W-1:0]     rdData,
  output logic [READ_PORTS-1:0]                 rdErr,
  output logic [READ_PORTS-1:0]                 storeErr
);
  function automatic logic [CRC_W-1:0] crcOf(input logic [DATA_W-1:0] w);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ w[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  localparam logic [CODE_W-1:0] RESET_CODE = hamEncode(crcOf('0));

  logic [DATA_W-1:0] words [REG_COUNT];
  logic [CODE_W-1:0] codes [REG_COUNT];
  logic [CODE_W-1:0] wrCode;

  assign wrCode = hamEncode(crcOf(wrData));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        words[i] <= '0;
        codes[i] <= RESET_CODE;
      end
    end else begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (strb.wrSel[i]) begin
          words[i] <= wrData;
          codes[i] <= wrCode;
        end else if (strb.injSel[i]) begin
          words[i] <= words[i] ^ injDataMask;
          codes[i] <= codes[i] ^ injCodeMask;
        end
      end
    end
  end

  for (genvar p = 0; p < READ_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] curWord;
    hamResult_t        curDec;
    logic              mismatch;

    always_comb begin
      curWord  = words[rdAddr[p]];
      curDec   = hamDecode(codes[rdAddr[p]]);
      mismatch = crcOf(curWord) != curDec.data;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[p]   <= '0;
        rdErr[p]    <= 1'b0;
        storeErr[p] <= 1'b0;
      end else begin
        rdData[p]   <= curWord;
        rdErr[p]    <= mismatch | curDec.dbl;
        storeErr[p] <= curDec.dbl;
      end
    end
  end

  // ---------------- assertions ----------------
  logic injSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                injSeen <= 1'b0;
    else if (|strb.injSel)    injSeen <= 1'b1;
  end

  // R3: with no corruption since reset, no port ever flags
  for (genvar p = 0; p < READ_PORTS; p++) begin : g_portChk
    p_clean_no_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
      !injSeen |-> (!rdErr[p] && !storeErr[p]));
  end

  // R10: the write decode and the injection decode never select the same register
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrSel & strb.injSel) == '0) && $onehot0(strb.wrSel));

  logic [CRC_W-1:0] liveCrc   [REG_COUNT];
  logic [CRC_W-1:0] storedCrc [REG_COUNT];
  always_comb begin
    for (int i = 0; i < REG_COUNT; i++) begin
      liveCrc[i]   = crcOf(words[i]);
      storedCrc[i] = hamDecode(codes[i]).data;
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_regChk
    // R5: a freshly written register holds a matching checksum
    p_write_match_r5: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrSel[i] |=> (liveCrc[i] == storedCrc[i]));
    // R4: a register neither written nor injected keeps its word
    p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.wrSel[i] && !strb.injSel[i]) |=> $stable(words[i]));
  end
endmodule

// File: rtl/crc_regfile.sv
module crc_regfile
  import crf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [DATA_W-1:0] injDataMask,
  input  logic [CODE_W-1:0] injCodeMask,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdErrA,
  output logic              storeErrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdErrB,
  output logic              storeErrB
);
  crfStrobes_t                          strb;
  logic [READ_PORTS-1:0][ADDR_W-1:0]    rdAddr;
  logic [READ_PORTS-1:0][DATA_W-1:0]    rdData;
  logic [READ_PORTS-1:0]                rdErr;
  logic [READ_PORTS-1:0]                storeErr;

  assign rdAddr    = {rdAddrB, rdAddrA};
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];
  assign rdErrA    = rdErr[0];
  assign rdErrB    = rdErr[1];
  assign storeErrA = storeErr[0];
  assign storeErrB = storeErr[1];

  crf_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .injEn   (injEn),
    .injAddr (injAddr),
    .strb    (strb)
  );

  crf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .injDataMask (injDataMask),
    .injCodeMask (injCodeMask),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .rdErr       (rdErr),
    .storeErr    (storeErr)
  );
endmodule

// File: tb/tb_crc_regfile.sv
module tb_crc_regfile;
  localparam int DW = 32;
  localparam int NR = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic injEn = 1'b0;
  logic [4:0] injAddr = '0;
  logic [DW-1:0] injDataMask = '0;
  logic [12:0] injCodeMask = '0;
  logic [4:0] rdAddrA = '0, rdAddrB = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic rdErrA, rdErrB, storeErrA, storeErrB;

  always #4 clk = ~clk;

  crc_regfile #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .injEn(injEn), .injAddr(injAddr), .injDataMask(injDataMask), .injCodeMask(injCodeMask),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdErrA(rdErrA), .storeErrA(storeErrA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .rdErrB(rdErrB), .storeErrB(storeErrB)
  );

  typedef struct {
    logic [DW-1:0] dA, dB;
    logic eA, eB, sA, sB;
    string req;
  } expItem_t;

  expItem_t q[$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [DW-1:0] mData [NR];
  logic [7:0]    mCrc  [NR];
  logic [12:0]   mFlip [NR];

  function automatic logic [7:0] refCrc(input logic [DW-1:0] w);
    logic [7:0] c = 8'h00;
    for (int b = DW - 1; b >= 0; b--) begin
      if (c[7] ^ w[b]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic expErr(input int r);
    if ($countones(mFlip[r]) >= 2) return 1'b1;
    return refCrc(mData[r]) != mCrc[r];
  endfunction

  function automatic logic expSErr(input int r);
    return $countones(mFlip[r]) >= 2;
  endfunction

  // One clock of stimulus; the expectation is taken from the model before the update (R6)
  task automatic cycleOp(input logic we, input int wa, input logic [DW-1:0] wd,
                         input logic ie, input int ia, input logic [DW-1:0] idm,
                         input logic [12:0] icm, input int ra, input int rb,
                         input string req);
    expItem_t it;
    @(negedge clk);
    wrEn = we; wrAddr = wa[4:0]; wrData = wd;
    injEn = ie; injAddr = ia[4:0]; injDataMask = idm; injCodeMask = icm;
    rdAddrA = ra[4:0]; rdAddrB = rb[4:0];
    it.dA = mData[ra]; it.eA = expErr(ra); it.sA = expSErr(ra);
    it.dB = mData[rb]; it.eB = expErr(rb); it.sB = expSErr(rb);
    it.req = req;
    q.push_back(it);
    if (ie && !(we && wa == ia)) begin
      mData[ia] = mData[ia] ^ idm;
      mFlip[ia] = mFlip[ia] ^ icm;
    end
    if (we) begin
      mData[wa] = wd; mCrc[wa] = refCrc(wd); mFlip[wa] = '0;
    end
  endtask

  task automatic rd(input int ra, input int rb, input string req);
    cycleOp(0, 0, '0, 0, 0, '0, '0, ra, rb, req);
  endtask
  task automatic wr(input int a, input logic [DW-1:0] d, input string req);
    cycleOp(1, a, d, 0, 0, '0, '0, 0, 0, req);
  endtask
  task automatic inj(input int a, input logic [DW-1:0] dm, input logic [12:0] cm, input string req);
    cycleOp(0, 0, '0, 1, a, dm, cm, 0, 0, req);
  endtask

  task automatic cmp(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop, sampled 2 ns after the rising edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.req, "dataA", rdDataA, it.dA);
        cmp(it.req, "errA", DW'(rdErrA), DW'(it.eA));
        cmp(it.req, "storeErrA", DW'(storeErrA), DW'(it.sA));
        cmp(it.req, "dataB", rdDataB, it.dB);
        cmp(it.req, "errB", DW'(rdErrB), DW'(it.eB));
        cmp(it.req, "storeErrB", DW'(storeErrB), DW'(it.sB));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mData[i] = '0; mCrc[i] = 8'h00; mFlip[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on both ports
    for (int i = 0; i < NR; i++) rd(i, NR - 1 - i, "R1");

    // R2: write patterns, read back one edge later
    wr(1, 32'hDEAD_BEEF, "R2");
    wr(2, 32'h0000_0001, "R2");
    wr(3, 32'h8000_0000, "R2");
    wr(7, 32'h1234_5678, "R2");
    wr(9, 32'hFFFF_FFFF, "R2");
    wr(12, 32'hA5A5_5A5A, "R2");
    rd(1, 2, "R2"); rd(3, 7, "R2"); rd(9, 12, "R2");

    // R6: read and write same address in the same cycle
    cycleOp(1, 1, 32'hCAFE_F00D, 0, 0, '0, '0, 1, 1, "R6");
    rd(1, 1, "R6");

    // R4: single, burst and odd-weight data upsets; neighbours stay clean
    inj(3, 32'h0000_0001, '0, "R4");
    inj(7, 32'h0000_00F0, '0, "R4");
    inj(9, 32'hFF00_0000, '0, "R4");
    inj(2, 32'h8000_0101, '0, "R4");
    rd(3, 4, "R4"); rd(7, 9, "R4"); rd(2, 1, "R4"); rd(3, 7, "R4");

    // R7: ports read a corrupted and a clean register in the same cycle
    rd(9, 12, "R7"); rd(12, 9, "R7");

    // R3: mask equal to the polynomial times x^4 escapes detection; data still changes
    inj(12, 32'h0000_1070, '0, "R3");
    rd(12, 12, "R3");
    inj(1, 32'h0107_0000, '0, "R3");
    rd(1, 0, "R3");

    // R5: rewriting clears data and codeword corruption
    wr(3, 32'h0BAD_F00D, "R5"); wr(7, 32'h7777_0000, "R5");
    rd(3, 7, "R5");

    // R8: single codeword flips corrected silently
    wr(14, 32'h1357_9BDF, "R8"); wr(15, 32'h2468_ACE0, "R8"); wr(16, 32'h0F0F_0F0F, "R8");
    inj(14, '0, 13'h0001, "R8");
    inj(15, '0, 13'h0020, "R8");
    inj(16, '0, 13'h1000, "R8");
    rd(14, 15, "R8"); rd(16, 14, "R8");

    // R9: double codeword flips reported
    wr(17, 32'h5555_AAAA, "R9"); wr(18, 32'h0000_0000, "R9");
    inj(17, '0, 13'h0003, "R9");
    inj(18, '0, 13'h1080, "R9");
    rd(17, 18, "R9"); rd(18, 16, "R9");
    wr(17, 32'h5555_AAAA, "R5");
    rd(17, 17, "R5");

    // R10: write beats injection on the same register; other register still injected
    cycleOp(1, 20, 32'h6789_ABCD, 1, 20, 32'h0000_FFFF, 13'h0003, 20, 20, "R10");
    rd(20, 20, "R10");
    cycleOp(1, 20, 32'h1111_2222, 1, 21, 32'h0000_0010, '0, 21, 20, "R10");
    rd(20, 21, "R10");

    rd(0, 0, "R1");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule